// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block gathers up to 64 interrupt lines, arranged as two banks of 32, and merges them into a single interrupt request to the processor. Most lines are edge-sensitive. A rising edge on such a line, while the line is enabled, latches a sticky event bit that stays set until software acknowledges it. A fixed per-controller mask marks some lines as level-sensitive. Those lines request service for as long as they are high and enabled, and they never latch an event.

Software uses a word-addressed register port. A write completes in one cycle. A read returns its data one cycle after the request, with a valid strobe. Each bank has four registers: event, enable, acknowledge and raw line state. The controller reports the highest-numbered pending source both on output pins and in a read-only register. A cascade input lets a second controller feed one line of this one.

All lines pass through a two-flop synchronizer before they are observed. Turning on the enable of a line that is already high does not create a request. A request needs a fresh rising edge.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every enable bit and every event bit is 0, `cpu_irq` is low, `top_valid` is low, and the identity register reads 32'hFFFF_FFFF.
- R2: Word addresses are: 0 = identity register; bank 0 (sources 0–31) at words 8..11; bank 1 (sources 32–63) at words 4..7. Within a bank, the order is base+0 event, base+1 enable, base+2 acknowledge (write only, reads 0), base+3 raw level. Read data and `bus_rvalid` appear in the cycle after the read request.
- R3: For an edge line, a rising edge of the synchronized input while the line's enable bit is 1 sets its event bit. A line that stays high sets nothing more.
- R4: Setting the enable bit of an edge line whose input is already high sets no event bit and does not raise `cpu_irq`.
- R5: Writing 1 to an acknowledge bit clears that event bit. Acknowledge bits written as 0 leave their event bits unchanged.
- R6: Lines in LVL_MASK are level-sensitive. With the default mask, these are bits 20–29 of bank 0 and none of bank 1. Such a line is pending while it is high and enabled, stops being pending when it falls, and never sets its event bit.
- R7: The pending set of a bank is (event OR (level AND mask)) AND enable. `cpu_irq` is high exactly when any bank has a pending bit.
- R8: The identity register and `top_id` give the highest-numbered pending source over all 64 lines, so bank 1 wins over bank 0. With nothing pending, the identity register reads all ones and `top_valid` is 0.
- R9: A written enable value is returned by a read issued in the next cycle. Writing 0 to the enable registers stops all requests.
- R10: `casc_line` is ORed into source line CASC_LINE (default 40, which is bank 1 bit 8) and behaves as an ordinary edge line.
- R11: The raw level register shows the synchronized state of every line, whatever the enable bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lines | input | 64 | Asynchronous interrupt lines |
| casc_line | input | 1 | Request from a cascaded controller |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| cpu_irq | output | 1 | Interrupt request to the processor |
| top_valid | output | 1 | A source is pending |
| top_id | output | 6 | Highest-numbered pending source |

## Verification
A stale or spurious event bit shows up two cycles after the edge that should or should not have set it. It is visible at once on `cpu_irq` and `top_id`, and one cycle later in an event register read. A wrong enable value shows in the read that follows the write. A fault in the priority encoder shows as a mismatch between `top_id` and the pending sources the bench knows it has raised, in the same cycle the pending set changes.

// File: rtl/bic_pkg.sv
package bic_pkg;
  typedef enum logic [1:0] {
    RG_EVENT  = 2'd0,
    RG_ENABLE = 2'd1,
    RG_ACK    = 2'd2,
    RG_LEVEL  = 2'd3
  } reg_sel_e;

  localparam int unsigned REGS_PER_BANK = 4;

  // word slot (address >> 2) holding a bank, bank 0 at the highest slot
  function automatic int unsigned bank_slot(input int unsigned nbanks, input int unsigned b);
    return nbanks - b;
  endfunction
endpackage

// File: rtl/bic_sync.sv
module bic_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] lvl_out,
  output logic [W-1:0] rise_out
);
  logic [W-1:0] st1_q, st2_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1_q  <= '0;
      st2_q  <= '0;
      prev_q <= '0;
    end else begin
      st1_q  <= raw_in;
      st2_q  <= st1_q;
      prev_q <= st2_q;
    end
  end

  assign lvl_out  = st2_q;
  assign rise_out = st2_q & ~prev_q;
endmodule

// File: rtl/bic_bank.sv
module bic_bank #(
  parameter int unsigned    W     = 32,
  parameter logic [W-1:0]   LMASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] lvl,
  input  logic         en_we,
  input  logic         ack_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] evt_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] pend
);
  logic [W-1:0] set_v, clr_v;

  assign set_v = rise & en_q & ~LMASK;
  assign clr_v = ack_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
      en_q  <= '0;
    end else begin
      evt_q <= (evt_q & ~clr_v) | set_v;
      if (en_we) en_q <= wdata;
    end
  end

  assign pend = (evt_q | (lvl & LMASK)) & en_q;

  AST_EVT_NO_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & ~$past(evt_q) & ~$past(rise & en_q)) == '0); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack_we) |-> ((evt_q & $past(wdata) & ~$past(rise & en_q)) == '0)); // R5
  AST_LVL_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & LMASK) == '0); // R6
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_we) |-> (en_q == $past(wdata))); // R9
endmodule

// File: rtl/bic_prio.sv
module bic_prio #(
  parameter int unsigned N    = 64,
  parameter int unsigned ID_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    pend,
  output logic            valid,
  output logic [ID_W-1:0] id
);
  always_comb begin
    id = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) id = ID_W'(i);
    end
  end
  assign valid = |pend;

  AST_PRIO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((pend >> id) == N'(1))); // R8
  AST_PRIO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (pend == '0)); // R8
endmodule

// File: rtl/bic_regif.sv
module bic_regif
  import bic_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [NUM_BANKS*DATA_W-1:0] evt_flat,
  input  logic [NUM_BANKS*DATA_W-1:0] en_flat,
  input  logic [NUM_BANKS*DATA_W-1:0] lvl_flat,
  input  logic [DATA_W-1:0]           id_word,
  output logic [NUM_BANKS-1:0]        en_we,
  output logic [NUM_BANKS-1:0]        ack_we,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic                        bus_rvalid
);
  localparam int unsigned SLOT_W = ADDR_W - 2;

  logic [SLOT_W-1:0] slot;
  reg_sel_e          field;
  logic [DATA_W-1:0] rd_mux;
  logic              rd_req;

  assign slot   = bus_addr[ADDR_W-1:2];
  assign field  = reg_sel_e'(bus_addr[1:0]);
  assign rd_req = bus_sel && !bus_wr;

  always_comb begin
    en_we  = '0;
    ack_we = '0;
    rd_mux = '0;
    if (slot == '0) rd_mux = id_word;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (slot == SLOT_W'(bank_slot(NUM_BANKS, b))) begin
        if (bus_sel && bus_wr) begin
          en_we[b]  = (field == RG_ENABLE);
          ack_we[b] = (field == RG_ACK);
        end
        unique case (field)
          RG_EVENT:  rd_mux = evt_flat[b*DATA_W +: DATA_W];
          RG_ENABLE: rd_mux = en_flat[b*DATA_W +: DATA_W];
          RG_ACK:    rd_mux = '0;
          RG_LEVEL:  rd_mux = lvl_flat[b*DATA_W +: DATA_W];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_req) |-> bus_rvalid); // R2
  AST_RD_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_req) |-> !bus_rvalid); // R2
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_we, ack_we})); // R2
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int unsigned                    NUM_BANKS = 2,
  parameter int unsigned                    DATA_W    = 32,
  parameter logic [NUM_BANKS*DATA_W-1:0]    LVL_MASK  = 64'h0000_0000_3ff0_0000,
  parameter int unsigned                    CASC_LINE = 40,
  localparam int unsigned                   NSRC      = NUM_BANKS * DATA_W,
  localparam int unsigned                   ID_W      = $clog2(NSRC),
  localparam int unsigned                   ADDR_W    = $clog2((NUM_BANKS + 1) * bic_pkg::REGS_PER_BANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lines,
  input  logic              casc_line,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              cpu_irq,
  output logic              top_valid,
  output logic [ID_W-1:0]   top_id
);
  logic [NSRC-1:0]      merged, lvl_all, rise_all, evt_all, en_all, pend_all;
  logic [NUM_BANKS-1:0] en_we, ack_we;
  logic [DATA_W-1:0]    id_word;

  always_comb begin
    merged            = src_lines;
    merged[CASC_LINE] = src_lines[CASC_LINE] | casc_line;
  end

  bic_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(merged),
    .lvl_out(lvl_all), .rise_out(rise_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bic_bank #(
      .W(DATA_W),
      .LMASK(LVL_MASK[b*DATA_W +: DATA_W])
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .rise(rise_all[b*DATA_W +: DATA_W]),
      .lvl(lvl_all[b*DATA_W +: DATA_W]),
      .en_we(en_we[b]), .ack_we(ack_we[b]), .wdata(bus_wdata),
      .evt_q(evt_all[b*DATA_W +: DATA_W]),
      .en_q(en_all[b*DATA_W +: DATA_W]),
      .pend(pend_all[b*DATA_W +: DATA_W])
    );
  end

  bic_prio #(.N(NSRC), .ID_W(ID_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pend_all),
    .valid(top_valid), .id(top_id)
  );

  assign id_word = top_valid ? DATA_W'(top_id) : '1;
  assign cpu_irq = |pend_all;

  bic_regif #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .evt_flat(evt_all), .en_flat(en_all), .lvl_flat(lvl_all),
    .id_word(id_word), .en_we(en_we), .ack_we(ack_we),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == top_valid); // R7
  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |-> !cpu_irq); // R9
endmodule

// File: tb/test_banked_irq_ctrl.sv
module test_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_lines = '0;
  logic        casc_line = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, cpu_irq, top_valid;
  logic [5:0]  top_id;

  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [3:0] A_ID = 4'd0;
  localparam logic [3:0] A1_EVT = 4'd4, A1_EN = 4'd5, A1_ACK = 4'd6, A1_LVL = 4'd7;
  localparam logic [3:0] A0_EVT = 4'd8, A0_EN = 4'd9, A0_ACK = 4'd10, A0_LVL = 4'd11;

  always #5 clk = ~clk;

  banked_irq_ctrl i_banked_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_lines(src_lines), .casc_line(casc_line),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cpu_irq(cpu_irq),
    .top_valid(top_valid), .top_id(top_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
    total++;
    if (bus_rvalid !== 1'b1) begin
      bad++;
      $display("FAIL R2: rvalid actual=%b expected=1", bus_rvalid);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 cpu_irq", {31'b0, cpu_irq}, 32'd0);
    chk("R1 top_valid", {31'b0, top_valid}, 32'd0);
    rd(A_ID, d);   chk("R1 id", d, 32'hFFFF_FFFF);
    rd(A0_EN, d);  chk("R1 en0", d, 32'd0);
    rd(A1_EN, d);  chk("R1 en1", d, 32'd0);
    rd(A0_EVT, d); chk("R1 evt0", d, 32'd0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(A0_EN, 32'h8);
    rd(A0_EN, d); chk("R9 en readback", d, 32'h8);
    src_lines[3] = 1; settle();
    rd(A0_EVT, d); chk("R3 evt set", d, 32'h8);
    chk("R7 irq", {31'b0, cpu_irq}, 32'd1);
    rd(A_ID, d); chk("R8 id3", d, 32'd3);
    wr(A0_ACK, 32'h0);
    rd(A0_EVT, d); chk("R5 ack zero", d, 32'h8);
    wr(A0_ACK, 32'h8); settle();
    rd(A0_EVT, d); chk("R3 no relatch while high", d, 32'h0);
    chk("R5 irq cleared", {31'b0, cpu_irq}, 32'd0);
    rd(A0_ACK, d); chk("R2 ack reads zero", d, 32'h0);
    src_lines[3] = 0; settle();
  endtask

  task automatic t_enable_high();
    logic [31:0] d;
    wr(A0_EN, 32'h0);
    src_lines[5] = 1; settle();
    wr(A0_EN, 32'h20); settle();
    rd(A0_EVT, d); chk("R4 evt stays 0", d, 32'h0);
    chk("R4 no irq", {31'b0, cpu_irq}, 32'd0);
    src_lines[5] = 0; settle();
    src_lines[5] = 1; settle();
    rd(A0_EVT, d); chk("R3 fresh edge", d, 32'h20);
    wr(A0_ACK, 32'h20);
    src_lines[5] = 0; wr(A0_EN, 32'h0); settle();
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(A0_EN, 32'h0040_0000);
    src_lines[22] = 1; settle();
    chk("R6 level irq", {31'b0, cpu_irq}, 32'd1);
    chk("R6 id22", {26'b0, top_id}, 32'd22);
    rd(A0_EVT, d); chk("R6 no evt", d, 32'h0);
    rd(A0_LVL, d); chk("R11 level reg", d, 32'h0040_0000);
    src_lines[22] = 0; settle();
    chk("R6 level drop", {31'b0, cpu_irq}, 32'd0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(A0_EN, 32'h0040_0008);
    wr(A1_EN, 32'h4);
    src_lines[3] = 1; src_lines[22] = 1; src_lines[34] = 1; settle();
    rd(A_ID, d); chk("R8 bank1 wins", d, 32'd34);
    chk("R8 top_id", {26'b0, top_id}, 32'd34);
    wr(A1_ACK, 32'h4); settle();
    rd(A_ID, d); chk("R8 next level", d, 32'd22);
    src_lines[22] = 0; settle();
    rd(A_ID, d); chk("R8 then edge", d, 32'd3);
    wr(A0_ACK, 32'h8); settle();
    rd(A_ID, d); chk("R8 none", d, 32'hFFFF_FFFF);
    src_lines[3] = 0; src_lines[34] = 0; settle();
  endtask

  task automatic t_cascade();
    logic [31:0] d;
    wr(A1_EN, 32'h100);
    casc_line = 1; settle();
    rd(A1_LVL, d); chk("R10 cascade level", d, 32'h100);
    rd(A1_EVT, d); chk("R10 cascade event", d, 32'h100);
    chk("R10 id40", {26'b0, top_id}, 32'd40);
    casc_line = 0; wr(A1_ACK, 32'h100); settle();
    chk("R10 cleared", {31'b0, cpu_irq}, 32'd0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(A0_EN, 32'h8);
    src_lines[3] = 1; settle();
    chk("R7 pending", {31'b0, cpu_irq}, 32'd1);
    wr(A0_EN, 32'h0); wr(A1_EN, 32'h0);
    @(negedge clk);
    chk("R9 irq off", {31'b0, cpu_irq}, 32'd0);
    rd(A_ID, d); chk("R9 id none", d, 32'hFFFF_FFFF);
    rd(A0_EN, d); chk("R9 en zero", d, 32'h0);
    src_lines[3] = 0; src_lines[10] = 1; settle();
    rd(A0_LVL, d); chk("R11 raw while disabled", d, 32'h400);
    src_lines[10] = 0; wr(A0_ACK, 32'hFFFF_FFFF); settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_edge();
    t_enable_high();
    t_level();
    t_priority();
    t_cascade();
    t_disable();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule